// File: doc/BRIEF.md
# Chip-Select Wait-State Bus Controller

This block turns single access requests into timed bus cycles for a small external bus. Each request's address is first sorted into one of six destinations. These are the special-function register window, internal RAM, internal ROM, and four external chip-select regions. The block then holds the request for the right number of bus clocks and drives the chip-select, strobe, address and data-direction pins for the whole of that time.

The length of an external cycle comes from a per-region setting. Each region has a no-wait flag and a two-bit extension code. A global wait flag can slow down the regions that are set to no-wait. A ready input can stretch cycles in regions that use wait states. The register window always uses a fixed length of two or three clocks, picked by one mode bit. Internal RAM and ROM accesses finish in a single clock and leave the external address and strobes untouched.

Configuration writes must follow an ordering rule that keeps the flag and the code of each region consistent. A write that breaks the rule is refused for the affected field, and a sticky error flag is raised.

Top module: `cs_wait_busctl`

## Requirements
- R1: After reset all chip selects, the read strobe and both write strobes are high (inactive), `busy`, `bus_doe` and `cfg_err` are 0, and every region is in with-wait mode with extension code 00, so an external cycle lasts 3 clocks.
- R2: Address decode: below 0x00400 is the register window, below 0x08000 is internal RAM, and 0xF0000 and above is internal ROM. Every other address is external, and its region number is address bits 19:18. For each external cycle exactly one `bus_cs_n` bit (the region number) is low, and it stays low for every clock of the cycle.
- R3: A region whose no-wait bit is 1 runs 2-clock cycles. A region whose no-wait bit is 0 runs 3, 4 or 5 clocks for extension codes 00, 01 and 10.
- R4: When the global wait bit (control bit 4) is set, no-wait regions run 3-clock cycles. With-wait regions are unaffected.
- R5: In a with-wait region, each clock sampled with `bus_rdy` low at or after the last programmed clock adds one clock. In a no-wait region `bus_rdy` is ignored.
- R6: Register-window cycles assert no chip select. They last 2 clocks, or 3 when control bit 5 is set, whatever the region settings, the global wait bit and `bus_rdy`.
- R7: An internal RAM/ROM access takes 1 clock. During it the address keeps the value of the previous external or register-window access, chip selects and strobes are high, and `bus_doe` is 0 for a read. For a write, `bus_doe` is 1 with the write data on `bus_dout`.
- R8: An extension-field write that would change the field of a region whose no-wait bit is 1 is refused. The field keeps its value.
- R9: An extension-field write of code 11 is refused for that region. The field keeps its value.
- R10: A control write that sets a region's no-wait bit while that region's extension code is not 00 is refused for that bit.
- R11: `bus_rd_n` is low for the whole of a read cycle. On a write, `bus_wr_n[k]` is low when byte enable k is set, and `bus_doe` is 1 with the data on `bus_dout`.
- R12: `done` is high on the last clock of every cycle. For external and register-window reads, `rd_data` holds the `bus_din` value sampled on that clock.
- R13: `cfg_err` goes high on any refused configuration write and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: control (bits 3:0 no-wait per region, bit 4 global wait, bit 5 three-clock register window); 1: extension codes (region i in bits 2i+1:2i) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_err | output | 1 | Sticky refused-write flag |
| req_valid | input | 1 | Access request, taken when `busy` is 0 |
| req_addr | input | 20 | Request address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_be | input | 2 | Byte-lane enables |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | Last clock of the current cycle |
| rd_data | output | 16 | Captured read data |
| bus_addr | output | 20 | Address pins |
| bus_cs_n | output | 4 | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 2 | Active-low per-lane write strobes |
| bus_doe | output | 1 | Data bus output enable |
| bus_dout | output | 16 | Data bus output value |
| bus_din | input | 16 | Data bus input value |
| bus_rdy | input | 1 | External ready, high when the device is ready |

## Verification
A request is taken at the clock edge where `busy` is 0, and the pins change at that same edge. The first clock of the cycle is therefore the one right after acceptance. The bench samples on falling edges from that clock on and counts the clocks up to and including the one where `done` is high, then compares that count with the length the requirements give. `bus_rdy` is changed on the falling edge before the clock it applies to. `rd_data` is read one edge after the `done` clock, and a configuration write takes effect one edge after its strobe. Every check waits for that edge before sampling.

// File: rtl/cs_wait_busctl.sv
`timescale 1ns/100ps
module cs_wait_busctl #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int NCS = 4,
  parameter logic [19:0] SFR_TOP = 20'h00400,
  parameter logic [19:0] RAM_TOP = 20'h08000,
  parameter logic [19:0] ROM_BASE = 20'hF0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic                  cfg_sel,
  input  logic [2*NCS-1:0]      cfg_wdata,
  output logic                  cfg_err,
  input  logic                  req_valid,
  input  logic [AW-1:0]         req_addr,
  input  logic                  req_write,
  input  logic [DW/8-1:0]       req_be,
  input  logic [DW-1:0]         req_wdata,
  output logic                  busy,
  output logic                  done,
  output logic [DW-1:0]         rd_data,
  output logic [AW-1:0]         bus_addr,
  output logic [NCS-1:0]        bus_cs_n,
  output logic                  bus_rd_n,
  output logic [DW/8-1:0]       bus_wr_n,
  output logic                  bus_doe,
  output logic [DW-1:0]         bus_dout,
  input  logic [DW-1:0]         bus_din,
  input  logic                  bus_rdy
);
  localparam int BW = DW/8;
  localparam int IW = $clog2(NCS);
  localparam int CW = 2*NCS;
  localparam int LW = 3;

  logic [NCS-1:0] nowait_q, nowait_d;
  logic           gwait_q, sfr3_q;
  logic [CW-1:0]  exp_q, exp_d;
  logic           cfg_bad;

  always_comb begin
    nowait_d = nowait_q;
    exp_d    = exp_q;
    cfg_bad  = 1'b0;
    if (!cfg_sel) begin
      for (int i = 0; i < NCS; i++) begin
        if (cfg_wdata[i] && !nowait_q[i] && exp_q[2*i +: 2] != 2'b00)
          cfg_bad = 1'b1;
        else
          nowait_d[i] = cfg_wdata[i];
      end
    end else begin
      for (int i = 0; i < NCS; i++) begin
        if (cfg_wdata[2*i +: 2] == 2'b11 ||
            (nowait_q[i] && cfg_wdata[2*i +: 2] != exp_q[2*i +: 2]))
          cfg_bad = 1'b1;
        else
          exp_d[2*i +: 2] = cfg_wdata[2*i +: 2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nowait_q <= '0;
      exp_q    <= '0;
      gwait_q  <= 1'b0;
      sfr3_q   <= 1'b0;
      cfg_err  <= 1'b0;
    end else if (cfg_we) begin
      nowait_q <= nowait_d;
      exp_q    <= exp_d;
      if (!cfg_sel) begin
        gwait_q <= cfg_wdata[NCS];
        sfr3_q  <= cfg_wdata[NCS+1];
      end
      if (cfg_bad) cfg_err <= 1'b1;
    end
  end

  wire           hit_sfr = req_addr < AW'(SFR_TOP);
  wire           hit_int = !hit_sfr && (req_addr < AW'(RAM_TOP) || req_addr >= AW'(ROM_BASE));
  wire [IW-1:0]  cs_idx  = req_addr[AW-1 -: IW];
  wire [1:0]     cs_code = exp_q[{cs_idx, 1'b0} +: 2];
  wire           start   = req_valid && !busy;

  logic [LW-1:0] last_d, last_q, cnt_q;
  logic          rdy_en_d, rdy_en_q, rd_q;

  always_comb begin
    rdy_en_d = 1'b0;
    if (hit_sfr)                last_d = sfr3_q ? LW'(2) : LW'(1);
    else if (hit_int)           last_d = LW'(0);
    else if (nowait_q[cs_idx])  last_d = gwait_q ? LW'(2) : LW'(1);
    else begin
      last_d   = LW'(2) + LW'(cs_code);
      rdy_en_d = 1'b1;
    end
  end

  assign done = busy && cnt_q == last_q && (!rdy_en_q || bus_rdy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt_q    <= '0;
      last_q   <= '0;
      rdy_en_q <= 1'b0;
      rd_q     <= 1'b0;
      rd_data  <= '0;
      bus_addr <= '0;
      bus_cs_n <= '1;
      bus_rd_n <= 1'b1;
      bus_wr_n <= '1;
      bus_doe  <= 1'b0;
      bus_dout <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      cnt_q    <= '0;
      last_q   <= last_d;
      rdy_en_q <= rdy_en_d;
      rd_q     <= !req_write && !hit_int;
      bus_doe  <= req_write;
      if (req_write) bus_dout <= req_wdata;
      if (!hit_int) begin
        bus_addr <= req_addr;
        bus_rd_n <= req_write;
        bus_wr_n <= ~(req_be & {BW{req_write}});
        if (!hit_sfr) bus_cs_n <= ~(NCS'(1) << cs_idx);
      end
    end else if (busy) begin
      if (done) begin
        busy     <= 1'b0;
        bus_cs_n <= '1;
        bus_rd_n <= 1'b1;
        bus_wr_n <= '1;
        bus_doe  <= 1'b0;
        if (rd_q) rd_data <= bus_din;
      end else if (cnt_q != last_q) begin
        cnt_q <= cnt_q + LW'(1);
      end
    end
  end
endmodule

// File: rtl/cs_wait_busctl_chk.sv
`timescale 1ns/100ps
module cs_wait_busctl_chk #(
  parameter int NCS = 4,
  parameter int BW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           done,
  input logic           cfg_err,
  input logic [NCS-1:0] bus_cs_n,
  input logic           bus_rd_n,
  input logic [BW-1:0]  bus_wr_n
);
  a_r2_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~bus_cs_n) <= 1);
  a_r2_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(bus_cs_n));
  a_r12_done_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r12_cycle_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r13_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cfg_err));
  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&bus_cs_n && bus_rd_n && &bus_wr_n));
  a_r11_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !(&bus_wr_n)));
endmodule

bind cs_wait_busctl cs_wait_busctl_chk #(.NCS(NCS), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cfg_err(cfg_err),
  .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
);

// File: tb/test_cs_wait_busctl.sv
`timescale 1ns/100ps
module test_cs_wait_busctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        cfg_err;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done;
  logic [15:0] rd_data;
  logic [19:0] bus_addr;
  logic [3:0]  bus_cs_n;
  logic        bus_rd_n;
  logic [1:0]  bus_wr_n;
  logic        bus_doe;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = 16'h0000;
  logic        bus_rdy = 1'b1;

  int checks = 0, errors = 0;
  int last_len, cs_bad;
  logic [19:0] s_addr;
  logic        s_rd_n, s_doe;
  logic [1:0]  s_wr_n;
  logic [15:0] s_dout;

  always #2.5 clk = ~clk;

  cs_wait_busctl i_cs_wait_busctl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_err(cfg_err), .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .req_be(req_be), .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_doe(bus_doe), .bus_dout(bus_dout), .bus_din(bus_din), .bus_rdy(bus_rdy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    cfg_we = 1'b0;
    bus_rdy = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg(input logic sel, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input logic [19:0] addr, input logic wr, input logic [1:0] be,
                     input logic [15:0] wd, input int hold, input logic [3:0] cs_exp);
    int n;
    bit fin;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_write = wr; req_be = be; req_wdata = wd;
    n = 0; fin = 0; cs_bad = 0;
    while (!fin) begin
      @(negedge clk);
      n++;
      if (n == 1) req_valid = 1'b0;
      bus_rdy = (n > hold);
      #1;
      if (n == 1) begin
        s_addr = bus_addr; s_rd_n = bus_rd_n; s_wr_n = bus_wr_n;
        s_doe = bus_doe; s_dout = bus_dout;
      end
      if (bus_cs_n !== cs_exp) cs_bad++;
      if (done || n > 40) fin = 1;
    end
    last_len = n;
    @(posedge clk);
    #1;
    bus_rdy = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 cs idle", bus_cs_n, 4'hF);
    chk("R1 rd idle", bus_rd_n, 1);
    chk("R1 wr idle", bus_wr_n, 2'b11);
    chk("R1 busy", busy, 0);
    chk("R1 doe", bus_doe, 0);
    chk("R1 err", cfg_err, 0);
  endtask

  task automatic t_default_read();
    bus_din = 16'hA55A;
    run(20'h40010, 1'b0, 2'b11, 16'h0, 0, 4'b1101);
    chk("R1 default length", last_len, 3);
    chk("R2 cs1 held", cs_bad, 0);
    chk("R11 rd strobe", s_rd_n, 0);
    chk("R2 address out", s_addr, 20'h40010);
    chk("R12 read data", rd_data, 16'hA55A);
    chk("R1 idle after", bus_cs_n, 4'hF);
  endtask

  task automatic t_codes();
    cfg(1'b1, 8'h90);
    run(20'h80000, 1'b0, 2'b11, 16'h0, 0, 4'b1011);
    chk("R3 code 01", last_len, 4);
    run(20'hC0000, 1'b0, 2'b11, 16'h0, 0, 4'b0111);
    chk("R3 code 10", last_len, 5);
    chk("R2 cs3 held", cs_bad, 0);
    run(20'h08000, 1'b0, 2'b11, 16'h0, 0, 4'b1110);
    chk("R3 code 00 cs0", last_len, 3);
    cfg(1'b1, 8'hD0);
    chk("R9 err set", cfg_err, 1);
    run(20'hC0000, 1'b0, 2'b11, 16'h0, 0, 4'b0111);
    chk("R9 cs3 kept 10", last_len, 5);
    run(20'h80000, 1'b0, 2'b11, 16'h0, 0, 4'b1011);
    chk("R9 cs2 kept 01", last_len, 4);
    cfg(1'b1, 8'h00);
    chk("R13 err sticky", cfg_err, 1);
  endtask

  task automatic t_nowait_global();
    do_reset();
    cfg(1'b0, 8'h01);
    run(20'h10000, 1'b0, 2'b11, 16'h0, 0, 4'b1110);
    chk("R3 nowait", last_len, 2);
    run(20'h10000, 1'b0, 2'b11, 16'h0, 3, 4'b1110);
    chk("R5 ready ignored", last_len, 2);
    cfg(1'b0, 8'h11);
    run(20'h10000, 1'b0, 2'b11, 16'h0, 0, 4'b1110);
    chk("R4 global wait", last_len, 3);
    run(20'h50000, 1'b0, 2'b11, 16'h0, 0, 4'b1101);
    chk("R4 with-wait unchanged", last_len, 3);
    chk("R1 err clear", cfg_err, 0);
  endtask

  task automatic t_ready();
    do_reset();
    run(20'h40000, 1'b0, 2'b11, 16'h0, 5, 4'b1101);
    chk("R5 ready stretch", last_len, 6);
    chk("R2 cs held stretch", cs_bad, 0);
    run(20'h40000, 1'b0, 2'b11, 16'h0, 1, 4'b1101);
    chk("R5 early ready", last_len, 3);
  endtask

  task automatic t_sfr();
    do_reset();
    bus_din = 16'h1234;
    run(20'h00100, 1'b0, 2'b11, 16'h0, 0, 4'hF);
    chk("R6 sfr 2 clk", last_len, 2);
    chk("R6 no cs", cs_bad, 0);
    chk("R12 sfr read", rd_data, 16'h1234);
    cfg(1'b0, 8'h3F);
    run(20'h00100, 1'b0, 2'b11, 16'h0, 4, 4'hF);
    chk("R6 sfr 3 clk", last_len, 3);
  endtask

  task automatic t_internal();
    do_reset();
    run(20'h40004, 1'b0, 2'b11, 16'h0, 0, 4'b1101);
    run(20'h01000, 1'b0, 2'b11, 16'h0, 0, 4'hF);
    chk("R7 int length", last_len, 1);
    chk("R7 addr held", s_addr, 20'h40004);
    chk("R7 rd high", s_rd_n, 1);
    chk("R7 read hi-z", s_doe, 0);
    run(20'hF8000, 1'b1, 2'b11, 16'hBEEF, 0, 4'hF);
    chk("R7 rom write len", last_len, 1);
    chk("R7 wr high", s_wr_n, 2'b11);
    chk("R7 write drive", s_doe, 1);
    chk("R7 write data", s_dout, 16'hBEEF);
    chk("R7 addr held w", s_addr, 20'h40004);
  endtask

  task automatic t_write();
    do_reset();
    run(20'h40020, 1'b1, 2'b10, 16'hC0DE, 0, 4'b1101);
    chk("R11 wr high lane", s_wr_n, 2'b01);
    chk("R11 rd high", s_rd_n, 1);
    chk("R11 doe", s_doe, 1);
    chk("R11 dout", s_dout, 16'hC0DE);
    chk("R3 write length", last_len, 3);
  endtask

  task automatic t_order_exp();
    do_reset();
    cfg(1'b0, 8'h02);
    cfg(1'b1, 8'h04);
    chk("R8 err", cfg_err, 1);
    run(20'h40000, 1'b0, 2'b11, 16'h0, 0, 4'b1101);
    chk("R8 field kept", last_len, 2);
    cfg(1'b0, 8'h00);
    cfg(1'b1, 8'h04);
    run(20'h40000, 1'b0, 2'b11, 16'h0, 0, 4'b1101);
    chk("R8 legal order", last_len, 4);
    chk("R13 still set", cfg_err, 1);
  endtask

  task automatic t_order_ctl();
    do_reset();
    cfg(1'b1, 8'h08);
    chk("R10 no err yet", cfg_err, 0);
    cfg(1'b0, 8'h02);
    chk("R10 err", cfg_err, 1);
    run(20'h40000, 1'b0, 2'b11, 16'h0, 0, 4'b1101);
    chk("R10 bit kept", last_len, 5);
    cfg(1'b1, 8'h00);
    cfg(1'b0, 8'h02);
    run(20'h40000, 1'b0, 2'b11, 16'h0, 0, 4'b1101);
    chk("R10 legal order", last_len, 2);
  endtask

  initial begin
    t_reset();
    t_default_read();
    t_codes();
    t_nowait_global();
    t_ready();
    t_sfr();
    t_internal();
    t_write();
    t_order_exp();
    t_order_ctl();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule